// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM that is eight bits wide. A master offers one read or one write at a time with a valid/ready handshake. The controller turns each accepted request into the active-low chip-select, output-enable and write-enable waveforms the memory expects. For reads it also captures the returned byte and marks it with a single-cycle valid pulse. Every analogue timing limit of the memory is turned into a whole number of clock cycles at elaboration. Each count is the ceiling of the limit divided by the clock period, and any nonzero limit gets at least one cycle.

After reset the controller waits out the memory's self-initialisation window before it accepts anything. It keeps the memory in standby (chip select high) between accesses. It also manages the shared data lines so that its own drivers and the memory's outputs never overlap. The pad tristate buffer lies outside the block: the controller supplies a data-out bus, a driver enable and a data-in bus.

The state machine has six states: `ST_POWERUP` (initialisation wait), `ST_IDLE` (standby, ready), `ST_READ` (read strobe), `ST_WR_TURN` (bus turnaround before driving), `ST_WR_PULSE` (write strobe) and `ST_WR_HOLD` (data held after the strobe). Its transitions are:
- pu_done: `ST_POWERUP` to `ST_IDLE`.
- accept_rd and accept_wr: `ST_IDLE` to `ST_READ` and to `ST_WR_TURN`.
- read_end: `ST_READ` to `ST_IDLE`.
- turn_end: `ST_WR_TURN` to `ST_WR_PULSE`.
- strobe_end: `ST_WR_PULSE` to `ST_WR_HOLD`.
- hold_end: `ST_WR_HOLD` to `ST_IDLE`.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays 0 and `mem_cs_n` stays 1 for the first PU = ceil(T_PU_NS/CLK_NS) clock edges. `req_ready` reads 1 after edge PU+1. A request held valid only during that window is dropped and never reaches the memory.
- R2: A read drives `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly ACC = max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)) consecutive cycles, with `mem_dq_oe`=0 throughout.
- R3: A write holds `mem_cs_n`=0 and `mem_we_n`=0 together for exactly WR = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS), ceil(T_AW_NS/CLK_NS)) cycles. During those cycles `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_out` equals the accepted write data. Both strobes return to 1 on the same edge, and that edge ends the write.
- R4: `rd_valid` is 1 for exactly one cycle, the cycle right after the last read-strobe cycle. `rd_data` then holds the value present on `mem_dq_in` during that last cycle.
- R5: `mem_dq_oe` rises only after `mem_oe_n` has been 1 for at least ceil(T_HZOE_NS/CLK_NS)+1 cycles. `mem_dq_oe` is 0 in the cycle before `mem_oe_n` falls. The two are never active together.
- R6: `mem_addr` does not change while `mem_cs_n` stays 0. Successive changes of `mem_addr` are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R7: `req_ready` is 1 only in standby, where `mem_cs_n`=1 and `mem_dq_oe`=0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_we`=1 selects a write and 0 selects a read.
- R8: While `rst_n`=0, the outputs read `mem_cs_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=0 and `rd_valid`=0.
- R9: The cycle after the strobes rise, `mem_dq_oe` is still 1 and `mem_dq_out` still holds the written byte. It is 0 the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read-data marker |
| rd_data | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Byte for the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Byte from the pads |

## Verification
Two things can land in the same clock cycle: the `rd_valid` pulse of a finished read, and the acceptance of a new write. Both occur in the standby cycle between them. The bench provokes this by raising the next request while a read is still under way, so the handshake completes in exactly the cycle the read result appears. It then judges that the returned byte matches the shadow contents and that the following write still passes through the full turnaround before its drivers switch on. The bench memory model returns a poison byte until the read strobe has lasted the access count, so any early capture shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_t;

    // ceiling division, at least one cycle for any nonzero limit
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        if (t_ns <= 0) return 0;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_powerup_gate.sv
module sram_powerup_gate #(
    parameter int CYCLES = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic init_done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign init_done = (cnt_q == '0);

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             last
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_PU_NS   = 150000,
    parameter int T_RC_NS   = 10,
    parameter int T_AA_NS   = 10,
    parameter int T_PWE_NS  = 8,
    parameter int T_AW_NS   = 8,
    parameter int T_SD_NS   = 6,
    parameter int T_HZOE_NS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PU_CYC   = imax(ns_to_cycles(T_PU_NS, CLK_NS), 1);
    localparam int ACC_CYC  = imax(imax(ns_to_cycles(T_AA_NS, CLK_NS),
                                        ns_to_cycles(T_RC_NS, CLK_NS)), 1);
    localparam int WR_CYC   = imax(imax(ns_to_cycles(T_PWE_NS, CLK_NS),
                                        ns_to_cycles(T_SD_NS, CLK_NS)),
                                   imax(ns_to_cycles(T_AW_NS, CLK_NS), 1));
    localparam int TURN_CYC = imax(ns_to_cycles(T_HZOE_NS, CLK_NS), 1);
    localparam int TMR_MAX  = imax(imax(ACC_CYC, WR_CYC), TURN_CYC);
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    ctrl_state_t       state_q, state_d;
    logic              pu_done;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    sram_powerup_gate #(.CYCLES(PU_CYC)) i_pu_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (pu_done)
    );

    sram_phase_timer #(.WIDTH(TMR_W)) i_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign accept = req_valid && req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_POWERUP: if (pu_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_d = ST_WR_TURN;
                        tmr_val = TMR_W'(TURN_CYC - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = TMR_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_READ:    if (tmr_last) state_d = ST_IDLE;
            ST_WR_TURN: begin
                if (tmr_last) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WR_CYC - 1);
                end
            end
            ST_WR_PULSE: if (tmr_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_POWERUP;
        endcase
    end

    // request capture and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            we_q       <= 1'b0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
            end
            if (state_q == ST_READ && tmr_last && !we_q) begin
                rd_data_q  <= mem_dq_in;
                rd_valid_q <= 1'b1;
            end
        end
    end

    // pin decode
    always_comb begin
        req_ready = 1'b0;
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_POWERUP:  ;
            ST_IDLE:     req_ready = 1'b1;
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_WR_TURN:  ;
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD:  mem_dq_oe = 1'b1;
            default:     ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rd_data_q;
    assign rd_valid   = rd_valid_q;

    // R1: nothing reaches the memory before initialisation ends
    a_r1_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (mem_cs_n && !req_ready));

    // R3: write strobe only with chip select, outputs off, drivers on
    a_r3_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    // R4: read marker is a single-cycle pulse
    a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5: drivers switch on only after output enable has been off
    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n)));

    // R5: output enable falls only with drivers already released
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));

    // R6: address steady while selected
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R7: ready only in standby
    a_r7_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_dq_oe));

    // R9: data still driven the cycle the strobes rise
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_cs_n && mem_dq_oe && $stable(mem_dq_out)));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

    localparam int CLK_PERIOD = 4;
    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int NWORD = 1 << AW;
    // expected counts at a 4 ns clock, from the requirement formulas
    localparam int PU   = 50;   // ceil(200/4)
    localparam int ACC  = 3;    // max(ceil(10/4), ceil(10/4))
    localparam int WR   = 2;    // max(ceil(8/4), ceil(6/4), ceil(8/4))
    localparam int TURN = 2;    // ceil(5/4)
    localparam int RC   = 3;    // ceil(10/4)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD), .T_PU_NS(200)
    ) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model: data valid only once the read strobe has lasted ACC cycles
    logic [DW-1:0] sram    [NWORD];
    logic [DW-1:0] ref_mem [NWORD];
    logic [DW-1:0] exp_q [$];
    int rd_run = 0;
    wire rd_cond = !mem_cs_n && !mem_oe_n && mem_we_n;

    always @(posedge clk) rd_run <= rd_cond ? rd_run + 1 : 0;
    assign mem_dq_in = (rd_cond && rd_run >= ACC - 1) ? sram[mem_addr] : 8'h5A;

    // waveform monitor, sampled mid-cycle
    int cyc = 0;
    int rd_len = 0, wr_len = 0, oe_hi_run = 1000, addr_age = 1000;
    bit rd_bad = 0, wr_bad = 0, prev_rd = 0, prev_wr = 0;
    bit prev_dq_oe = 0, prev_oe_n = 1, prev_cs_n = 1;
    logic [DW-1:0] wr_byte = '0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit cur_rd, cur_wr;
            cyc++;
            cur_rd = !mem_cs_n && !mem_oe_n && mem_we_n;
            cur_wr = !mem_cs_n && !mem_we_n;
            // R1: hold-off window
            if (cyc <= PU) chk(!req_ready && mem_cs_n, "R1 hold-off", req_ready, 0);
            if (cyc == PU + 1) chk(req_ready, "R1 ready after init", req_ready, 1);
            // R2 / R4: read end
            if (prev_rd && !cur_rd) begin
                chk(rd_len == ACC && !rd_bad, "R2 read strobe length", rd_len, ACC);
                chk(rd_valid, "R4 rd_valid after read", rd_valid, 1);
                if (exp_q.size() > 0) begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R4 read data", rd_data, e);
                end else chk(0, "R4 unexpected read", 1, 0);
                rd_len = 0; rd_bad = 0;
            end else if (rd_valid) chk(0, "R4 stray rd_valid", 1, 0);
            if (cur_rd) begin
                rd_len++;
                if (mem_dq_oe) rd_bad = 1;
            end
            // R3 / R9: write end
            if (prev_wr && !cur_wr) begin
                chk(wr_len == WR && !wr_bad, "R3 write strobe", wr_len, WR);
                chk(mem_cs_n && mem_we_n, "R3 strobes rise together", {mem_cs_n, mem_we_n}, 3);
                chk(mem_dq_oe && mem_dq_out == wr_byte, "R9 data hold", mem_dq_out, wr_byte);
                sram[mem_addr] = wr_byte;
                wr_len = 0; wr_bad = 0;
            end
            if (prev_dq_oe && !prev_wr && mem_dq_oe) chk(0, "R9 drivers held too long", 1, 0);
            if (cur_wr) begin
                if (wr_len == 0) wr_byte = mem_dq_out;
                else if (mem_dq_out != wr_byte) wr_bad = 1;
                if (!mem_oe_n || !mem_dq_oe) wr_bad = 1;
                wr_len++;
            end
            // R5: turnaround
            if (mem_dq_oe && !prev_dq_oe)
                chk(oe_hi_run >= TURN + 1, "R5 drive after oe high", oe_hi_run, TURN + 1);
            if (!mem_oe_n && prev_oe_n)
                chk(!prev_dq_oe && !mem_dq_oe, "R5 release before oe low", prev_dq_oe, 0);
            if (mem_dq_oe && !mem_oe_n) chk(0, "R5 bus fight", 1, 0);
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            // R6: address spacing
            if (mem_addr != prev_addr) begin
                chk(addr_age >= RC, "R6 address spacing", addr_age, RC);
                chk(prev_cs_n || mem_cs_n, "R6 address moved while selected", prev_cs_n, 1);
                addr_age = 1;
            end else addr_age++;
            // R7: ready only in standby
            if (req_ready) chk(mem_cs_n && !mem_dq_oe, "R7 standby", mem_cs_n, 1);
            prev_rd = cur_rd; prev_wr = cur_wr; prev_dq_oe = mem_dq_oe;
            prev_oe_n = mem_oe_n; prev_cs_n = mem_cs_n; prev_addr = mem_addr;
        end
    end

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic issue(input bit we, input int a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d;
        if (we) ref_mem[a] = d;
        else    exp_q.push_back(ref_mem[a]);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + 11);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        for (int i = 0; i < NWORD; i++) begin
            sram[i] = 8'hC3; ref_mem[i] = 8'hC3;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R8 strobes idle in reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !req_ready && !rd_valid, "R8 outputs quiet in reset",
            {mem_dq_oe, req_ready, rd_valid}, 0);
        #1 rst_n = 1'b1;
        // R1: request offered during hold-off, then withdrawn
        req_valid = 1'b1; req_we = 1'b1; req_addr = 4'd5; req_wdata = 8'hAA;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        issue(0, 5, '0);                      // R1: must return untouched C3
        for (int a = 0; a < NWORD; a++) issue(1, a, pat(a));
        for (int a = 0; a < NWORD; a++) issue(0, a, '0);
        // read result and next write acceptance fall in one cycle
        for (int a = 0; a < NWORD; a++) begin
            issue(1, a, ~pat(a));
            issue(0, (a + 7) % NWORD, '0);
        end
        for (int a = NWORD - 1; a >= 0; a--) issue(0, a, '0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
        summary_and_end();
    end

endmodule